// File: doc/BRIEF.md
# Tagged hex serial stream demultiplexer

This block sits behind a serial receiver that carries the traffic of two input devices, a keyboard and a mouse, over one link. The far end sends every payload byte as two ASCII hexadecimal characters. In front of each pair it puts a one-character tag that names the device the byte belongs to. The block takes at most one received character per cycle. It recognises the tags, decodes the hex digits and rebuilds each binary byte. It then presents the byte on one of two output channels, each with a valid/ready handshake.

A tag opens a byte. The next two hex characters, high nibble first, complete it. Characters that arrive outside a byte, such as line breaks, spaces or stray digits, are dropped without comment. A malformed byte raises a one-cycle error pulse, and the parser goes back to waiting for a tag. A fresh tag in the middle of a byte restarts parsing for the newly named channel. Each channel holds one byte. If that byte has not been taken, a newly completed byte for the channel is discarded and a sticky overflow flag for the channel is set.

Top module: `tagged_hex_split`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, both output valids, both overflow flags and the error pulse are low, and the parser waits for a tag.
- R2: The keyboard tag (parameter KBD_TAG, default 8'h4B 'K') followed by two hex digits presents the byte {first digit, second digit} on the keyboard output. kbd_valid rises in the cycle after the second digit is taken.
- R3: The mouse tag (parameter MSE_TAG, default 8'h4D 'M') followed by two hex digits delivers the byte on the mouse output with the same timing.
- R4: Digits 8'h30-8'h39 map to 0-9, and both 8'h41-8'h46 and 8'h61-8'h66 map to 10-15.
- R5: A character that is neither a tag nor a hex digit, arriving after a tag or after the first digit, ends that byte with no output. It raises err_pulse for exactly the following cycle and returns the parser to waiting for a tag.
- R6: While the parser waits for a tag, every non-tag character is ignored. It produces no output, no error and no change to the next byte.
- R7: A tag arriving after a tag or after a first digit discards the partial byte without an error and starts a new byte for the channel that tag names.
- R8: While a channel's valid is high and its ready is low, the valid stays high and the data does not change.
- R9: A byte that completes for a channel whose valid is high and whose ready is low is dropped. That channel's overflow flag then goes high and stays high until reset, and the held byte is kept.
- R10: A cycle with in_valid low consumes no character and leaves the parse state unchanged.
- R11: A byte that completes in the same cycle as a handshake on its channel replaces the departing byte without setting overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received character is present this cycle |
| in_char | input | 8 | Received character |
| kbd_valid | output | 1 | Keyboard byte available |
| kbd_ready | input | 1 | Keyboard consumer accepts the byte |
| kbd_data | output | 8 | Keyboard byte |
| mse_valid | output | 1 | Mouse byte available |
| mse_ready | input | 1 | Mouse consumer accepts the byte |
| mse_data | output | 8 | Mouse byte |
| kbd_ovf | output | 1 | Sticky: a keyboard byte was dropped |
| mse_ovf | output | 1 | Sticky: a mouse byte was dropped |
| err_pulse | output | 1 | One-cycle pulse on a malformed byte |

## Verification
The bench builds the block with the default tags 'K' and 'M'. Neither is a hex digit, so a tag always ends the current byte and both restart and malformed-byte paths can be reached from text alone. By holding each ready low on its own, the bench brings the overflow of one channel within reach while the other channel's flag must stay clear. Releasing ready in the cycle a byte completes reaches the back-to-back replacement case.

// File: rtl/tagged_hex_split.sv
module tagged_hex_split #(
  parameter logic [7:0] KBD_TAG = 8'h4B,
  parameter logic [7:0] MSE_TAG = 8'h4D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_char,
  output logic       kbd_valid,
  input  logic       kbd_ready,
  output logic [7:0] kbd_data,
  output logic       mse_valid,
  input  logic       mse_ready,
  output logic [7:0] mse_data,
  output logic       kbd_ovf,
  output logic       mse_ovf,
  output logic       err_pulse
);
  localparam logic [1:0] S_WAIT = 2'd0, S_HI = 2'd1, S_LO = 2'd2;

  logic [1:0] state;
  logic       to_mse;
  logic [3:0] hi_nib;
  logic [3:0] nib;
  logic       is_hex;

  always_comb begin
    is_hex = 1'b1;
    nib    = in_char[3:0];
    if (in_char >= 8'h30 && in_char <= 8'h39)
      nib = in_char[3:0];
    else if ((in_char >= 8'h41 && in_char <= 8'h46) || (in_char >= 8'h61 && in_char <= 8'h66))
      nib = in_char[3:0] + 4'd9;
    else
      is_hex = 1'b0;
  end

  wire tag_k  = in_valid && in_char == KBD_TAG;
  wire tag_m  = in_valid && in_char == MSE_TAG;
  wire plain  = in_valid && !tag_k && !tag_m;
  wire bad    = plain && state != S_WAIT && !is_hex;
  wire done   = plain && state == S_LO && is_hex;
  wire [7:0] full = {hi_nib, nib};
  wire load_k = done && !to_mse;
  wire load_m = done && to_mse;
  wire busy_k = kbd_valid && !kbd_ready;
  wire busy_m = mse_valid && !mse_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_WAIT;
      to_mse    <= 1'b0;
      hi_nib    <= 4'd0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= bad;
      if (tag_k || tag_m) begin
        state  <= S_HI;
        to_mse <= tag_m;
      end else if (plain && state != S_WAIT) begin
        if (!is_hex)
          state <= S_WAIT;
        else if (state == S_HI) begin
          hi_nib <= nib;
          state  <= S_LO;
        end else
          state <= S_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kbd_valid <= 1'b0;
      kbd_data  <= 8'd0;
      kbd_ovf   <= 1'b0;
    end else begin
      if (load_k && !busy_k) begin
        kbd_valid <= 1'b1;
        kbd_data  <= full;
      end else if (kbd_ready)
        kbd_valid <= 1'b0;
      if (load_k && busy_k)
        kbd_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mse_valid <= 1'b0;
      mse_data  <= 8'd0;
      mse_ovf   <= 1'b0;
    end else begin
      if (load_m && !busy_m) begin
        mse_valid <= 1'b1;
        mse_data  <= full;
      end else if (mse_ready)
        mse_valid <= 1'b0;
      if (load_m && busy_m)
        mse_ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/tagged_hex_split_chk.sv
module tagged_hex_split_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       kbd_valid,
  input logic       kbd_ready,
  input logic [7:0] kbd_data,
  input logic       mse_valid,
  input logic       mse_ready,
  input logic [7:0] mse_data,
  input logic       kbd_ovf,
  input logic       mse_ovf,
  input logic       err_pulse
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !kbd_valid && !mse_valid && !kbd_ovf && !mse_ovf && !err_pulse);

  assert_kbd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid && !kbd_ready |=> kbd_valid && $stable(kbd_data));

  assert_mse_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mse_valid && !mse_ready |=> mse_valid && $stable(mse_data));

  assert_kbd_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_ovf |=> kbd_ovf);

  assert_mse_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mse_ovf |=> mse_ovf);

  assert_kbd_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbd_ovf) |-> $past(kbd_valid && !kbd_ready));

  assert_mse_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mse_ovf) |-> $past(mse_valid && !mse_ready));

  assert_err_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  assert_err_needs_char_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(in_valid));

  assert_kbd_rise_needs_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbd_valid) |-> $past(in_valid));

  assert_mse_rise_needs_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mse_valid) |-> $past(in_valid));
endmodule

bind tagged_hex_split tagged_hex_split_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .kbd_valid(kbd_valid), .kbd_ready(kbd_ready), .kbd_data(kbd_data),
  .mse_valid(mse_valid), .mse_ready(mse_ready), .mse_data(mse_data),
  .kbd_ovf(kbd_ovf), .mse_ovf(mse_ovf), .err_pulse(err_pulse)
);

// File: tb/tagged_hex_split_tb_top.sv
`timescale 1ns/1ps
module tagged_hex_split_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_char = 8'd0;
  logic kbd_ready = 1'b1, mse_ready = 1'b1;
  logic kbd_valid, mse_valid, kbd_ovf, mse_ovf, err_pulse;
  logic [7:0] kbd_data, mse_data;

  always #2.5 clk = ~clk;

  tagged_hex_split dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
    .kbd_valid(kbd_valid), .kbd_ready(kbd_ready), .kbd_data(kbd_data),
    .mse_valid(mse_valid), .mse_ready(mse_ready), .mse_data(mse_data),
    .kbd_ovf(kbd_ovf), .mse_ovf(mse_ovf), .err_pulse(err_pulse)
  );

  int tests = 0, fails = 0, err_seen = 0;
  bit finished = 0;
  logic [7:0] kq[$], mq[$];

  // behavioural reference
  int m_phase = 0, m_ch = 0, m_hi = 0, m_kd = 0, m_md = 0;
  bit m_kv = 0, m_mv = 0, m_kovf = 0, m_movf = 0, m_err = 0;

  function automatic int hexval(input logic [7:0] c);
    if (c >= "0" && c <= "9") return int'(c) - 48;
    if (c >= "A" && c <= "F") return int'(c) - 55;
    if (c >= "a" && c <= "f") return int'(c) - 87;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_ch = 0; m_hi = 0; m_kv = 0; m_mv = 0;
      m_kovf = 0; m_movf = 0; m_err = 0; m_kd = 0; m_md = 0;
    end else begin
      bit kb, mb;
      int h;
      kb = m_kv && !kbd_ready;
      mb = m_mv && !mse_ready;
      if (m_kv && kbd_ready) m_kv = 0;
      if (m_mv && mse_ready) m_mv = 0;
      m_err = 0;
      if (in_valid) begin
        h = hexval(in_char);
        if (in_char == "K") begin m_phase = 1; m_ch = 0; end
        else if (in_char == "M") begin m_phase = 1; m_ch = 1; end
        else if (m_phase != 0) begin
          if (h < 0) begin m_err = 1; m_phase = 0; end
          else if (m_phase == 1) begin m_hi = h; m_phase = 2; end
          else begin
            m_phase = 0;
            if (m_ch == 0) begin
              if (kb) m_kovf = 1; else begin m_kv = 1; m_kd = m_hi * 16 + h; end
            end else begin
              if (mb) m_movf = 1; else begin m_mv = 1; m_md = m_hi * 16 + h; end
            end
          end
        end
      end
    end
  end

  task automatic fail_msg(input string req, input int act, input int exp);
    fails++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    tests++;
    if (kbd_valid !== m_kv || mse_valid !== m_mv || kbd_ovf !== m_kovf ||
        mse_ovf !== m_movf || err_pulse !== m_err ||
        (m_kv && kbd_data !== m_kd[7:0]) || (m_mv && mse_data !== m_md[7:0]))
      fail_msg("cycle model R2/R3/R5/R8/R9",
               {kbd_valid, mse_valid, kbd_ovf, mse_ovf, err_pulse, kbd_data, mse_data},
               {m_kv, m_mv, m_kovf, m_movf, m_err, m_kd[7:0], m_md[7:0]});
    if (kbd_valid && kbd_ready) kq.push_back(kbd_data);
    if (mse_valid && mse_ready) mq.push_back(mse_data);
    if (err_pulse) err_seen++;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) fail_msg(req, act, exp);
  endtask

  task automatic send(input logic [7:0] c);
    in_valid = 1'b1; in_char = c;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pop_k(input string req, input int exp);
    if (kq.size() == 0) fail_msg(req, -1, exp);
    else chk(req, int'(kq.pop_front()), exp);
  endtask

  task automatic pop_m(input string req, input int exp);
    if (mq.size() == 0) fail_msg(req, -1, exp);
    else chk(req, int'(mq.pop_front()), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valids/flags in reset", {kbd_valid, mse_valid, kbd_ovf, mse_ovf, err_pulse}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", {kbd_valid, mse_valid, kbd_ovf, mse_ovf, err_pulse}, 0);

    send("K"); send("3");
    chk("R2 no output before 2nd digit", kbd_valid, 0);
    send("C");
    #1.5 chk("R2 kbd_valid next cycle", kbd_valid, 1);
    chk("R2 kbd_data", kbd_data, 8'h3C);
    #1; idle(2);
    pop_k("R2 keyboard byte", 8'h3C);

    send("M"); send("a"); send("F"); idle(2);
    pop_m("R3 mouse byte, R4 lowercase", 8'hAF);
    chk("R3 nothing on keyboard", kq.size(), 0);

    send("K"); send("0"); send("9"); send("K"); send("F"); send("f"); idle(2);
    pop_k("R4 digit 9 range", 8'h09);
    pop_k("R4 mixed case F", 8'hFF);

    e0 = err_seen;
    send(8'h0D); send(8'h0A); send(" "); send("5"); send("A");
    send("K"); send("1"); send("2"); idle(2);
    chk("R6 no error in wait", err_seen - e0, 0);
    pop_k("R6 wait chars ignored", 8'h12);
    chk("R6 single byte only", kq.size(), 0);

    e0 = err_seen;
    send("K"); send("4"); send("G"); send("7"); send("7"); idle(2);
    chk("R5 one error pulse", err_seen - e0, 1);
    chk("R5 nothing delivered", kq.size() + mq.size(), 0);
    e0 = err_seen;
    send("M"); send("z"); idle(2);
    chk("R5 error after tag", err_seen - e0, 1);

    e0 = err_seen;
    send("K"); send("5"); send("M"); send("6"); send("7"); idle(2);
    pop_m("R7 restart to mouse", 8'h67);
    chk("R7 partial dropped", kq.size(), 0);
    chk("R7 no error", err_seen - e0, 0);

    send("K"); idle(1); send("8"); idle(2); send("1"); idle(2);
    pop_k("R10 gaps keep state", 8'h81);

    kbd_ready = 1'b0;
    send("K"); send("A"); send("B"); idle(3);
    chk("R8 valid held", kbd_valid, 1);
    chk("R8 data held", kbd_data, 8'hAB);
    send("K"); send("C"); send("D"); idle(1);
    chk("R9 kbd overflow", kbd_ovf, 1);
    chk("R9 held byte kept", kbd_data, 8'hAB);
    chk("R9 mouse flag clear", mse_ovf, 0);
    kbd_ready = 1'b1; idle(3);
    pop_k("R9 original delivered", 8'hAB);
    chk("R9 new byte dropped", kq.size(), 0);
    chk("R9 flag sticky", kbd_ovf, 1);

    mse_ready = 1'b0;
    send("M"); send("1"); send("1"); idle(1);
    send("M"); send("2");
    mse_ready = 1'b1;
    send("2"); idle(3);
    pop_m("R11 first byte", 8'h11);
    pop_m("R11 replacing byte", 8'h22);
    chk("R11 no overflow", mse_ovf, 0);

    idle(2);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule